// File: doc/BRIEF.md
# Asynchronous Static Memory Read Sequencer

This block runs one read access at a time on an asynchronous static memory bus. A host presents an address and a chip-select index together with a request. When the block is idle it takes the request and drives the address onto the memory address bus. It then lowers the read strobe and the selected chip-select line, each at its own programmed point in the access. It samples the data bus when the strobe returns high. At the end of the access it hands the byte back with a one-cycle response pulse.

All timing comes from plain input ports and is counted in clock cycles. These values are latched when a request is taken. The strobe has a setup count and a pulse count, and the chip select has its own pair. Both windows sit inside one shared access length. A window that would run past the end of the access is cut off there. Whatever time is left after a line rises becomes its address hold interval.

Top module: `async_read_seq`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is 1, `mem_rd_n` and all bits of `mem_cs_n` are 1. Reset also clears `rsp_valid` to 0 and `mem_addr` to 0, and sets `req_ready` to 1.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, `req_ready` is 0. A request raised while the block is busy is ignored: it changes neither the address, the chip-select choice nor the response timing.
- R3: `mem_addr` shows the taken address from the first cycle of the access. It holds that value through the access, the response cycle and any idle time, until the next request is taken.
- R4: Number the cycles of an access k = 0, 1, … starting with the cycle right after the accepting edge. `mem_rd_n` is 0 exactly in the cycles where k ≥ rd_setup, k < rd_setup + rd_pulse, and k < the access length.
- R5: `mem_cs_n[i]` follows the same rule using cs_setup and cs_pulse, but only for i equal to the latched `req_cs` index. All other chip-select bits stay 1, so at most one bit is ever 0.
- R6: Let the access length C be `t_cycle`, with a value of 0 treated as 1. `rsp_valid` is 1 for exactly one cycle, in cycle k = C.
- R7: With `rsp_valid`, `rsp_data` holds the value `mem_rdata` had in the last cycle where `mem_rd_n` was 0. If the strobe never went low in that access, `rsp_data` is 0.
- R8: A pulse count of 0 keeps that line high for the whole access. A setup count of 0 lowers the line in cycle k = 0. A window that reaches past C ends at C.
- R9: `req_ready` is 1 in the response cycle. A request presented then is taken at the next edge, so accesses can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host requests a read |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Address for the read |
| req_cs | input | SW | Index of the chip-select line to assert |
| t_rd_setup | input | CW | Strobe setup count |
| t_rd_pulse | input | CW | Strobe low count |
| t_cs_setup | input | CW | Chip-select setup count |
| t_cs_pulse | input | CW | Chip-select low count |
| t_cycle | input | CW | Total access length in cycles (0 is taken as 1) |
| mem_addr | output | AW | Memory address bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_rdata | input | DW | Memory data bus |
| rsp_valid | output | 1 | One-cycle pulse: read finished |
| rsp_data | output | DW | Captured read byte |

## Verification
The bench builds the block with CW = 4, AW = 24, DW = 8 and NCS = 4. It sweeps every strobe setup and pulse value from 0 to 3 against every chip-select setup and pulse value from 0 to 3. Each of these combinations is run for access lengths 0 through 6, with the chip-select index rotating through all four lines. This narrow count width covers every case: windows that end before the access does, windows cut short at its end, windows that never open, a zero access length, and back-to-back accesses. The expected output for each cycle is computed from the window arithmetic. The per-cycle data pattern on the bus shows which cycle was captured.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rdseq_timer.sv
module rdseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cyc_len,
  output logic          run_q,
  output logic          run_nxt,
  output logic [CW-1:0] k_nxt,
  output logic          done_q
);
  import rdseq_pkg::*;

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_eff;

  assign len_eff = (cyc_len == '0) ? CW'(1) : cyc_len;
  assign run_q   = (state_q == SEQ_RUN);

  always_comb begin
    k_nxt   = cnt_q;
    run_nxt = 1'b0;
    if (state_q == SEQ_RUN) begin
      k_nxt   = cnt_q + 1'b1;
      run_nxt = (k_nxt != len_eff);
    end else if (start) begin
      k_nxt   = '0;
      run_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= run_nxt ? SEQ_RUN : SEQ_IDLE;
      cnt_q   <= k_nxt;
      done_q  <= run_q && !run_nxt;
    end
  end
endmodule

// File: rtl/rdseq_window.sv
module rdseq_window #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_nxt,
  input  logic [CW-1:0] k_nxt,
  input  logic [CW-1:0] setup,
  input  logic [CW-1:0] pulse,
  output logic          act_nxt,
  output logic          act_q
);
  logic [CW:0] open_at;
  logic [CW:0] close_at;
  logic [CW:0] k_ext;

  assign open_at  = {1'b0, setup};
  assign close_at = open_at + {1'b0, pulse};
  assign k_ext    = {1'b0, k_nxt};
  assign act_nxt  = run_nxt && (k_ext >= open_at) && (k_ext < close_at);

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_nxt;
  end
endmodule

// File: rtl/rdseq_csdec.sv
module rdseq_csdec #(
  parameter int NCS = 4,
  localparam int SW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           act_nxt,
  input  logic [SW-1:0]  sel_nxt,
  output logic [NCS-1:0] cs_n_q
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) cs_n_q[i] <= 1'b1;
      else     cs_n_q[i] <= !(act_nxt && (sel_nxt == SW'(i)));
    end
  end
endmodule

// File: rtl/async_read_seq.sv
module async_read_seq #(
  parameter int AW  = 24,
  parameter int DW  = 8,
  parameter int NCS = 4,
  parameter int CW  = 8,
  localparam int SW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [SW-1:0]  req_cs,
  input  logic [CW-1:0]  t_rd_setup,
  input  logic [CW-1:0]  t_rd_pulse,
  input  logic [CW-1:0]  t_cs_setup,
  input  logic [CW-1:0]  t_cs_pulse,
  input  logic [CW-1:0]  t_cycle,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd_n,
  output logic [NCS-1:0] mem_cs_n,
  input  logic [DW-1:0]  mem_rdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data
);
  logic          accept;
  logic          run_q, run_nxt;
  logic [CW-1:0] k_nxt;

  logic [CW-1:0] rs_q, rp_q, ss_q, sp_q, cyc_q;
  logic [CW-1:0] rs_n, rp_n, ss_n, sp_n, cyc_n;
  logic [SW-1:0] sel_q, sel_n;
  logic          rd_act_nxt, rd_act_q;
  logic          cs_act_nxt, cs_act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cap_q;

  assign req_ready = !run_q;
  assign accept    = req_valid && req_ready;

  assign rs_n  = accept ? t_rd_setup : rs_q;
  assign rp_n  = accept ? t_rd_pulse : rp_q;
  assign ss_n  = accept ? t_cs_setup : ss_q;
  assign sp_n  = accept ? t_cs_pulse : sp_q;
  assign cyc_n = accept ? t_cycle    : cyc_q;
  assign sel_n = accept ? req_cs     : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q   <= '0;
      rp_q   <= '0;
      ss_q   <= '0;
      sp_q   <= '0;
      cyc_q  <= '0;
      sel_q  <= '0;
      addr_q <= '0;
    end else begin
      rs_q  <= rs_n;
      rp_q  <= rp_n;
      ss_q  <= ss_n;
      sp_q  <= sp_n;
      cyc_q <= cyc_n;
      sel_q <= sel_n;
      if (accept) addr_q <= req_addr;
    end
  end

  rdseq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .cyc_len (cyc_n),
    .run_q   (run_q),
    .run_nxt (run_nxt),
    .k_nxt   (k_nxt),
    .done_q  (rsp_valid)
  );

  rdseq_window #(.CW(CW)) u_rd_win (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (run_nxt),
    .k_nxt   (k_nxt),
    .setup   (rs_n),
    .pulse   (rp_n),
    .act_nxt (rd_act_nxt),
    .act_q   (rd_act_q)
  );

  rdseq_window #(.CW(CW)) u_cs_win (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (run_nxt),
    .k_nxt   (k_nxt),
    .setup   (ss_n),
    .pulse   (sp_n),
    .act_nxt (cs_act_nxt),
    .act_q   (cs_act_q)
  );

  rdseq_csdec #(.NCS(NCS)) u_csdec (
    .clk     (clk),
    .rst     (rst),
    .act_nxt (cs_act_nxt),
    .sel_nxt (sel_n),
    .cs_n_q  (mem_cs_n)
  );

  // Sample the bus on the edge where the strobe returns high.
  always_ff @(posedge clk) begin
    if (rst || accept)                cap_q <= '0;
    else if (rd_act_q && !rd_act_nxt) cap_q <= mem_rdata;
  end

  logic cs_unused;
  assign cs_unused = cs_act_q;

  assign mem_addr = addr_q;
  assign mem_rd_n = !rd_act_q;
  assign rsp_data = cap_q;
endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
  parameter int AW  = 24,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_rd_n,
  input logic [NCS-1:0] mem_cs_n,
  input logic           rsp_valid
);
  p_idle_lines_high_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_rd_n && (&mem_cs_n)));

  p_take_goes_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(mem_addr));

  p_one_select_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(~mem_cs_n) <= 1);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_ready_at_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
endmodule

bind async_read_seq rdseq_checker #(.AW(AW), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_rd_n  (mem_rd_n),
  .mem_cs_n  (mem_cs_n),
  .rsp_valid (rsp_valid)
);

// File: tb/tb_async_read_seq.sv
module tb_async_read_seq;
  localparam int AW = 24, DW = 8, NCS = 4, CW = 4, SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_cs = '0;
  logic [CW-1:0] t_rd_setup = '0, t_rd_pulse = '0, t_cs_setup = '0, t_cs_pulse = '0, t_cycle = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd_n;
  logic [NCS-1:0] mem_cs_n;
  logic [DW-1:0] mem_rdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  async_read_seq #(.AW(AW), .DW(DW), .NCS(NCS), .CW(CW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cs(req_cs),
    .t_rd_setup(t_rd_setup), .t_rd_pulse(t_rd_pulse),
    .t_cs_setup(t_cs_setup), .t_cs_pulse(t_cs_pulse), .t_cycle(t_cycle),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic bit in_win(int k, int s, int p, int c);
    return (k >= s) && (k < s + p) && (k < c);
  endfunction

  function automatic logic [DW-1:0] bus_val(int k, int n);
    return DW'((k * 37 + n * 11 + 8'h5A) & 8'hFF);
  endfunction

  // Run one access; called at a negedge, returns at the negedge of the response cycle.
  task automatic run_access(input int n, input int rs, input int rp, input int ss,
                            input int sp, input int c, input int sel, input bit intrude);
    int ceff;
    logic [AW-1:0] a;
    logic [DW-1:0] exp_d;
    logic [NCS-1:0] exp_cs;
    ceff = (c == 0) ? 1 : c;
    a = AW'(32'h00A5_0000 + n * 32'h0001_0203);
    exp_d = '0;
    req_valid = 1'b1;
    req_addr = a;
    req_cs = SW'(sel);
    t_rd_setup = CW'(rs); t_rd_pulse = CW'(rp);
    t_cs_setup = CW'(ss); t_cs_pulse = CW'(sp);
    t_cycle = CW'(c);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < ceff; k++) begin
      mem_rdata = bus_val(k, n);
      if (in_win(k, rs, rp, ceff)) exp_d = bus_val(k, n);
      exp_cs = '1;
      if (in_win(k, ss, sp, ceff)) exp_cs[sel] = 1'b0;
      chk("R2 busy", {31'b0, req_ready}, 32'd0);
      chk("R3 addr", {8'b0, mem_addr}, {8'b0, a});
      chk("R4 rd_n", {31'b0, mem_rd_n}, {31'b0, !in_win(k, rs, rp, ceff)});
      chk("R5 cs_n", {28'b0, mem_cs_n}, {28'b0, exp_cs});
      chk("R6 early", {31'b0, rsp_valid}, 32'd0);
      if (intrude && k == 0) begin
        // R2: a request while busy must be ignored.
        req_valid = 1'b1;
        req_addr = ~a;
        req_cs = SW'(sel + 1);
        t_cycle = CW'(1);
      end
      @(posedge clk);
      @(negedge clk);
      if (intrude) req_valid = 1'b0;
    end
    chk("R6 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk("R7 rsp_data", {24'b0, rsp_data}, {24'b0, exp_d});
    chk("R9 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rd idle", {31'b0, mem_rd_n}, 32'd1);
    chk("R1 cs idle", {28'b0, mem_cs_n}, 32'hF);
    chk("R3 addr rsp", {8'b0, mem_addr}, {8'b0, a});
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rd_n", {31'b0, mem_rd_n}, 32'd1);
    chk("R1 cs_n", {28'b0, mem_cs_n}, 32'hF);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 addr", {8'b0, mem_addr}, 32'd0);

    // Sweep: R4 R5 R6 R7 R8, accesses back to back (R9).
    n = 0;
    for (int c = 0; c <= 6; c++)
      for (int rs = 0; rs < 4; rs++)
        for (int rp = 0; rp < 4; rp++)
          for (int ss = 0; ss < 4; ss++)
            for (int sp = 0; sp < 4; sp++) begin
              run_access(n, rs, rp, ss, sp, c, n % 4, 1'b0);
              n++;
            end

    // Idle gap: response pulse ends, lines stay high, address holds (R1, R3, R6).
    @(negedge clk);
    chk("R6 one cycle", {31'b0, rsp_valid}, 32'd0);
    chk("R1 idle rd", {31'b0, mem_rd_n}, 32'd1);
    chk("R3 idle addr", {8'b0, mem_addr}, {8'b0, AW'(32'h00A5_0000 + (n - 1) * 32'h0001_0203)});

    // R2: intruding requests during long accesses.
    for (int sel = 0; sel < 4; sel++) begin
      run_access(n, 1, 2, 0, 4, 5, sel, 1'b1);
      n++;
      @(negedge clk);
    end

    // R8: windows running past the end are cut off.
    run_access(n, 2, 15, 3, 15, 4, 2, 1'b0);
    n++;
    run_access(n, 0, 15, 0, 15, 15, 1, 1'b0);
    finish_run();
  end
endmodule